// File: doc/BRIEF.md
# Write-Guarded Translation Lookaside Buffer

This block translates 32-bit virtual byte addresses into 30-bit physical byte addresses through a small, fully associative table of page mappings. Pages are 4 KB. The low twelve address bits go through untouched. The upper twenty bits are looked up against the tags held in eight entries. Each entry stores a 20-bit virtual page tag, an 18-bit physical page number, a valid flag, a modified (dirty) flag and a write-permission flag.

A lookup request carries an address and a read/write flag. One clock later the block reports one of three outcomes. The first is a successful translation. The second is a miss exception, raised when no valid entry holds the page. The third is a protection exception, raised when a write targets a page that does not permit writes. The hardware never walks page tables. Software handles every exception and loads new mappings through a fill port that writes one entry per cycle. A single flush input discards every mapping at once. A write that is allowed marks its entry as modified, and that flag is reported with each successful translation.

Top module: `tlb_guarded`

## Requirements
- R1: After reset every entry is invalid and all response outputs are 0, so any lookup after reset reports a miss.
- R2: A lookup that hits is answered on the clock edge after the request: rsp_valid=1, rsp_hit=1, and rsp_paddr = {entry physical page number, vaddr[11:0]}. The tag is vaddr[31:12].
- R3: Only an entry with its valid flag set can take part in a hit. A stale tag in an invalid entry gives a miss.
- R4: When no valid entry matches, the response has rsp_miss_exc=1, rsp_hit=0 and rsp_paddr=0, and the table is not changed by the miss.
- R5: A write that matches an entry without write permission gives rsp_prot_exc=1, rsp_hit=0 and rsp_paddr=0, and it leaves that entry's dirty flag clear.
- R6: A read that matches an entry without write permission is a normal hit with no exception.
- R7: A permitted write hit sets the entry's dirty flag. On every hit, rsp_dirty reports the entry's dirty flag including the effect of the current access. A fill clears the flag. rsp_dirty is 0 on any response that is not a hit.
- R8: When fill_en=1, the entry at fill_idx is written with the given tag, page number and permission, marked valid and not dirty, at that clock edge. A lookup in the same cycle sees the table as it was before the fill.
- R9: When flush_all=1, every valid flag is cleared at that clock edge. A fill in the same cycle is discarded.
- R10: If several valid entries hold the same tag, the one with the lowest index supplies the translation and the permission.
- R11: In a cycle after one with req_valid=0, rsp_valid, rsp_hit, rsp_miss_exc, rsp_prot_exc, rsp_dirty and rsp_paddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_vaddr | input | 32 | Virtual byte address to translate |
| fill_en | input | 1 | Write one table entry this cycle |
| fill_idx | input | 3 | Entry index to write |
| fill_vpn | input | 20 | Virtual page tag for the filled entry |
| fill_ppn | input | 18 | Physical page number for the filled entry |
| fill_wr_ok | input | 1 | Filled page permits writes |
| flush_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 30 | Physical byte address, 0 unless hit |
| rsp_dirty | output | 1 | Dirty flag of the hit entry after this access |
| rsp_miss_exc | output | 1 | No valid mapping for the page |
| rsp_prot_exc | output | 1 | Write to a page without write permission |

## Verification
The hardest situation to reach from the ports is a set of mappings that should never coexist: duplicate tags in two valid entries, or a stale tag left behind in an invalid entry. The stimulus builds the first case by filling the same tag into a low and a high index, and the second by flushing and then refilling only other slots. It then drives fill, flush and lookup in the same cycle, which shows that a lookup sees the old table and that a flush discards a fill. The dirty flag is followed through write hits, rejected writes and refills by reading the same page back afterwards.

// File: rtl/tlb_guarded_pkg.sv
package tlb_guarded_pkg;

   // Outcome of one lookup, decided combinationally and then registered.
   typedef enum logic [1:0] {
      XL_IDLE = 2'd0,
      XL_HIT  = 2'd1,
      XL_MISS = 2'd2,
      XL_PROT = 2'd3
   } xl_kind_e;

   localparam int unsigned DEF_VA_W    = 32;
   localparam int unsigned DEF_PA_W    = 30;
   localparam int unsigned DEF_OFFS_W  = 12;
   localparam int unsigned DEF_ENTRIES = 8;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PPN_W   = 18,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           flush_all,
   input  logic                           fill_en,
   input  logic [IDX_W-1:0]               fill_idx,
   input  logic [VPN_W-1:0]               fill_vpn,
   input  logic [PPN_W-1:0]               fill_ppn,
   input  logic                           fill_wr_ok,
   input  logic                           mark_en,
   input  logic [IDX_W-1:0]               mark_idx,
   output logic [ENTRIES-1:0]             ent_valid,
   output logic [ENTRIES-1:0]             ent_dirty,
   output logic [ENTRIES-1:0]             ent_wr_ok,
   output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
   output logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic fill_here;
      logic mark_here;
      assign fill_here = fill_en && (fill_idx == IDX_W'(e));
      assign mark_here = mark_en && (mark_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_dirty[e] <= 1'b0;
            ent_wr_ok[e] <= 1'b0;
            ent_vpn[e]   <= '0;
            ent_ppn[e]   <= '0;
         end else if (flush_all) begin
            ent_valid[e] <= 1'b0;
         end else if (fill_here) begin
            ent_valid[e] <= 1'b1;
            ent_dirty[e] <= 1'b0;
            ent_wr_ok[e] <= fill_wr_ok;
            ent_vpn[e]   <= fill_vpn;
            ent_ppn[e]   <= fill_ppn;
         end else if (mark_here) begin
            ent_dirty[e] <= 1'b1;
         end
      end
   end

   // R9: a flush leaves no valid entry behind
   a_r9_flush_clears : assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (ent_valid == '0));

   // R8: a fill lands in the addressed slot as a valid mapping
   a_r8_fill_lands : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush_all) |=>
         (ent_valid[$past(fill_idx)] && !ent_dirty[$past(fill_idx)] &&
          ent_vpn[$past(fill_idx)] == $past(fill_vpn)));

   // R7: a permitted write marks its entry modified
   a_r7_dirty_mark : assert property (@(posedge clk) disable iff (!rst_n)
      (mark_en && !flush_all && !(fill_en && fill_idx == mark_idx)) |=>
         ent_dirty[$past(mark_idx)]);

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PPN_W   = 18,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [VPN_W-1:0]               lk_vpn,
   input  logic [ENTRIES-1:0]             ent_valid,
   input  logic [ENTRIES-1:0]             ent_dirty,
   input  logic [ENTRIES-1:0]             ent_wr_ok,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
   input  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
   output logic                           any_hit,
   output logic [IDX_W-1:0]               sel_idx,
   output logic [PPN_W-1:0]               sel_ppn,
   output logic                           sel_wr_ok,
   output logic                           sel_dirty
);

   logic [ENTRIES-1:0] hit_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = ent_valid[e] && (ent_vpn[e] == lk_vpn);
   end

   // Scan from the top down so that the lowest matching index is kept last.
   always_comb begin
      sel_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hit_vec[e]) begin
            sel_idx = IDX_W'(e);
         end
      end
   end

   assign any_hit   = |hit_vec;
   assign sel_ppn   = ent_ppn[sel_idx];
   assign sel_wr_ok = ent_wr_ok[sel_idx];
   assign sel_dirty = ent_dirty[sel_idx];

   // R10: no matching entry below the chosen one
   a_r10_lowest_first : assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> ((hit_vec & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0));

   // R3: the chosen entry is valid and carries the looked-up tag
   a_r3_valid_only : assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> (ent_valid[sel_idx] && ent_vpn[sel_idx] == lk_vpn));

endmodule

// File: rtl/tlb_resp.sv
module tlb_resp
   import tlb_guarded_pkg::*;
#(
   parameter int unsigned OFFS_W = 12,
   parameter int unsigned PPN_W  = 18,
   localparam int unsigned PA_W  = PPN_W + OFFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [OFFS_W-1:0] req_off,
   input  logic              any_hit,
   input  logic [PPN_W-1:0]  sel_ppn,
   input  logic              sel_wr_ok,
   input  logic              sel_dirty,
   output logic              mark_en,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_dirty,
   output logic              rsp_miss_exc,
   output logic              rsp_prot_exc
);

   xl_kind_e kind;

   always_comb begin
      if (!req_valid)                   kind = XL_IDLE;
      else if (!any_hit)                kind = XL_MISS;
      else if (req_write && !sel_wr_ok) kind = XL_PROT;
      else                              kind = XL_HIT;
   end

   assign mark_en = (kind == XL_HIT) && req_write;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_paddr    <= '0;
         rsp_dirty    <= 1'b0;
         rsp_miss_exc <= 1'b0;
         rsp_prot_exc <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_hit      <= (kind == XL_HIT);
         rsp_miss_exc <= (kind == XL_MISS);
         rsp_prot_exc <= (kind == XL_PROT);
         rsp_paddr    <= (kind == XL_HIT) ? {sel_ppn, req_off} : '0;
         rsp_dirty    <= (kind == XL_HIT) && (sel_dirty || req_write);
      end
   end

   // R4: no matching entry yields a miss exception and no address
   a_r4_miss_raised : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_hit) |=> (rsp_miss_exc && !rsp_hit && rsp_paddr == '0));

   // R5: a write to a page without write permission is refused
   a_r5_write_refused : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && any_hit && !sel_wr_ok) |=>
         (rsp_prot_exc && !rsp_hit && rsp_paddr == '0));

   // R6: reads never raise the protection exception
   a_r6_read_allowed : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && any_hit) |=> (rsp_hit && !rsp_prot_exc));

   // R2: the page offset passes through unchanged on a hit
   a_r2_offset_kept : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_paddr[OFFS_W-1:0] == $past(req_off)));

   // R11: no request, quiet response
   a_r11_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss_exc && !rsp_prot_exc));

endmodule

// File: rtl/tlb_guarded.sv
module tlb_guarded
   import tlb_guarded_pkg::*;
#(
   parameter int unsigned VA_W    = DEF_VA_W,
   parameter int unsigned PA_W    = DEF_PA_W,
   parameter int unsigned OFFS_W  = DEF_OFFS_W,
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   localparam int unsigned VPN_W  = VA_W - OFFS_W,
   localparam int unsigned PPN_W  = PA_W - OFFS_W,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic              fill_wr_ok,
   input  logic              flush_all,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_dirty,
   output logic              rsp_miss_exc,
   output logic              rsp_prot_exc
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_guarded: ENTRIES must be at least 2");
   end
   if (OFFS_W >= PA_W || OFFS_W >= VA_W) begin : g_bad_offset
      $error("tlb_guarded: page offset must be narrower than both addresses");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0]             ent_dirty;
   logic [ENTRIES-1:0]             ent_wr_ok;
   logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
   logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
   logic                           any_hit;
   logic [IDX_W-1:0]               sel_idx;
   logic [PPN_W-1:0]               sel_ppn;
   logic                           sel_wr_ok;
   logic                           sel_dirty;
   logic                           mark_en;

   tlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_all  (flush_all),
      .fill_en    (fill_en),
      .fill_idx   (fill_idx),
      .fill_vpn   (fill_vpn),
      .fill_ppn   (fill_ppn),
      .fill_wr_ok (fill_wr_ok),
      .mark_en    (mark_en),
      .mark_idx   (sel_idx),
      .ent_valid  (ent_valid),
      .ent_dirty  (ent_dirty),
      .ent_wr_ok  (ent_wr_ok),
      .ent_vpn    (ent_vpn),
      .ent_ppn    (ent_ppn)
   );

   tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (req_vaddr[VA_W-1:OFFS_W]),
      .ent_valid (ent_valid),
      .ent_dirty (ent_dirty),
      .ent_wr_ok (ent_wr_ok),
      .ent_vpn   (ent_vpn),
      .ent_ppn   (ent_ppn),
      .any_hit   (any_hit),
      .sel_idx   (sel_idx),
      .sel_ppn   (sel_ppn),
      .sel_wr_ok (sel_wr_ok),
      .sel_dirty (sel_dirty)
   );

   tlb_resp #(.OFFS_W(OFFS_W), .PPN_W(PPN_W)) u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_off      (req_vaddr[OFFS_W-1:0]),
      .any_hit      (any_hit),
      .sel_ppn      (sel_ppn),
      .sel_wr_ok    (sel_wr_ok),
      .sel_dirty    (sel_dirty),
      .mark_en      (mark_en),
      .rsp_valid    (rsp_valid),
      .rsp_hit      (rsp_hit),
      .rsp_paddr    (rsp_paddr),
      .rsp_dirty    (rsp_dirty),
      .rsp_miss_exc (rsp_miss_exc),
      .rsp_prot_exc (rsp_prot_exc)
   );

endmodule

// File: tb/tlb_guarded_tb.sv
module tlb_guarded_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        fill_en = 1'b0;
   logic [2:0]  fill_idx = '0;
   logic [19:0] fill_vpn = '0;
   logic [17:0] fill_ppn = '0;
   logic        fill_wr_ok = 1'b0;
   logic        flush_all = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_dirty, rsp_miss_exc, rsp_prot_exc;
   logic [29:0] rsp_paddr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tlb_guarded u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
      .fill_ppn(fill_ppn), .fill_wr_ok(fill_wr_ok), .flush_all(flush_all),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
      .rsp_dirty(rsp_dirty), .rsp_miss_exc(rsp_miss_exc), .rsp_prot_exc(rsp_prot_exc)
   );

   localparam int K_HIT  = 1;
   localparam int K_MISS = 2;
   localparam int K_PROT = 3;

   // {write, vaddr, kind, ppn, dirty}
   localparam int NV = 11;
   localparam logic [53:0] VEC [NV] = '{
      {1'b0, 32'h0000_1ABC, 2'd1, 18'h00AAA, 1'b0},
      {1'b1, 32'h0000_1FFF, 2'd1, 18'h00AAA, 1'b1},
      {1'b0, 32'h0000_1000, 2'd1, 18'h00AAA, 1'b1},
      {1'b0, 32'h1234_5678, 2'd1, 18'h3FFFF, 1'b0},
      {1'b1, 32'h1234_5678, 2'd3, 18'h00000, 1'b0},
      {1'b0, 32'h1234_5000, 2'd1, 18'h3FFFF, 1'b0},
      {1'b0, 32'hFFFF_FFFF, 2'd1, 18'h00001, 1'b0},
      {1'b1, 32'h0000_0004, 2'd1, 18'h20000, 1'b1},
      {1'b0, 32'hABCD_E123, 2'd2, 18'h00000, 1'b0},
      {1'b1, 32'h0000_2000, 2'd2, 18'h00000, 1'b0},
      {1'b0, 32'h0000_1001, 2'd1, 18'h00AAA, 1'b1}
   };

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   function automatic logic [63:0] rsp_word();
      return 64'({rsp_valid, rsp_hit, rsp_miss_exc, rsp_prot_exc, rsp_dirty, rsp_paddr});
   endfunction

   function automatic logic [63:0] exp_word(input int kind, input logic [31:0] va,
                                            input logic [17:0] ppn, input logic dty);
      logic [29:0] pa;
      pa = (kind == K_HIT) ? {ppn, va[11:0]} : 30'd0;
      return 64'({1'b1, kind == K_HIT, kind == K_MISS, kind == K_PROT,
                  (kind == K_HIT) && dty, pa});
   endfunction

   task automatic fill(input logic [2:0] idx, input logic [19:0] vpn,
                       input logic [17:0] ppn, input logic wr);
      @(negedge clk);
      fill_en = 1'b1; fill_idx = idx; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = wr;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk);
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
   endtask

   task automatic look(input string rq, input logic wr, input logic [31:0] va,
                       input int kind, input logic [17:0] ppn, input logic dty);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk(rq, rsp_word(), exp_word(kind, va, ppn, dty));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 outputs during reset", rsp_word(), 64'd0);
      rst_n = 1'b1;
      look("R1 lookup after reset misses", 1'b0, 32'h0000_1000, K_MISS, '0, 1'b0);

      @(negedge clk);
      chk("R11 idle cycle quiet", rsp_word(), 64'd0);

      // R8: fill and lookup of the same page in one cycle sees the old table
      @(negedge clk);
      fill_en = 1'b1; fill_idx = 3'd0; fill_vpn = 20'h00001; fill_ppn = 18'h00AAA; fill_wr_ok = 1'b1;
      req_valid = 1'b1; req_write = 1'b0; req_vaddr = 32'h0000_1ABC;
      @(negedge clk);
      fill_en = 1'b0; req_valid = 1'b0;
      chk("R8 same-cycle lookup sees old table", rsp_word(), exp_word(K_MISS, 32'h0000_1ABC, '0, 1'b0));

      fill(3'd1, 20'h12345, 18'h3FFFF, 1'b0);
      fill(3'd2, 20'hFFFFF, 18'h00001, 1'b1);
      fill(3'd3, 20'h00000, 18'h20000, 1'b1);
      fill(3'd5, 20'h12345, 18'h11111, 1'b1); // duplicate tag, higher index

      for (int i = 0; i < NV; i++) begin
         look($sformatf("R2/R4/R5/R6/R7/R10 table row %0d", i), VEC[i][53], VEC[i][52:21],
              int'(VEC[i][20:19]), VEC[i][18:1], VEC[i][0]);
      end

      // R7: refill clears the dirty flag
      fill(3'd0, 20'h00001, 18'h00AAA, 1'b1);
      look("R7 refill clears dirty", 1'b0, 32'h0000_1ABC, K_HIT, 18'h00AAA, 1'b0);

      // R9: flush wins over a fill in the same cycle
      @(negedge clk);
      flush_all = 1'b1;
      fill_en = 1'b1; fill_idx = 3'd4; fill_vpn = 20'h55555; fill_ppn = 18'h05555; fill_wr_ok = 1'b1;
      @(negedge clk);
      flush_all = 1'b0; fill_en = 1'b0;
      look("R9 fill dropped under flush", 1'b0, 32'h5555_5000, K_MISS, '0, 1'b0);
      look("R9 flushed entry misses", 1'b0, 32'h0000_1000, K_MISS, '0, 1'b0);

      // R3: stale tags in invalid slots never hit
      fill(3'd7, 20'h77777, 18'h07777, 1'b1);
      look("R3 valid refilled slot hits", 1'b0, 32'h7777_7123, K_HIT, 18'h07777, 1'b0);
      look("R3 stale invalid tag misses", 1'b1, 32'h0000_1123, K_MISS, '0, 1'b0);

      // R10: lowest index wins, also for permission
      fill(3'd6, 20'h33333, 18'h00006, 1'b1);
      fill(3'd2, 20'h33333, 18'h00002, 1'b0);
      look("R10 lowest index supplies page", 1'b0, 32'h3333_3ABC, K_HIT, 18'h00002, 1'b0);
      look("R10 lowest index supplies permission", 1'b1, 32'h3333_3ABC, K_PROT, '0, 1'b0);

      // R4: a miss leaves the table intact
      look("R4 miss on unknown page", 1'b1, 32'h4444_4000, K_MISS, '0, 1'b0);
      look("R4 table intact after miss", 1'b1, 32'h7777_7FFF, K_HIT, 18'h07777, 1'b1);

      flush();
      look("R9 explicit flush empties table", 1'b0, 32'h7777_7000, K_MISS, '0, 1'b0);

      @(negedge clk);
      chk("R11 quiet after last request", rsp_word(), 64'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule